// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Port Decoder

This block is the device-side control decoder of an asynchronous 16-bit memory port, split into two 8-bit byte lanes. It takes the pin-level controls (an active-low select, an active-high select, an active-low write strobe, an active-low output enable and one active-low enable per byte lane) and works out for every lane whether the lane drives its output data, whether it is being written, and which power mode the port is in. A small register-array store sits behind the decoder so the port can be exercised on its own.

The pins are asynchronous to the design, so a fast internal clock samples them once and all decode results are registered. A write is treated as an overlap window per lane: the lane is written while the select pins, the write strobe and that lane's enable are all active. When the overlap closes, the lane commits the address and data seen at the last sample inside the window. Output drive is modelled as a per-lane enable next to a data bus that reads zero on undriven lanes.

Top module: `dual_lane_sram_port`

## Requirements
- R1: The port is in standby (mode 2'b00), with no lane driven and no lane strobed, whenever the active-low select is high, the active-high select is low, or every lane enable is high.
- R2: With the port selected, write strobe high and output enable low, mode is 2'b10, drive_en[i] is 1 exactly for the lanes whose enable lane_n[i] is 0, and each driven lane shows its stored byte on rdata.
- R3: With the port selected, write strobe high and output enable high, mode is 2'b01 (active, output disabled) and no lane is driven.
- R4: With the port selected and write strobe low, mode is 2'b11 whatever the output enable, wr_stb[i] is 1 exactly for the lanes whose enable is 0, and no lane is driven.
- R5: When a lane's write overlap closes, that lane stores the address and data sampled at the last clock inside the overlap; lanes that were not enabled keep their stored byte.
- R6: A lane's write overlap closes as soon as any one of the write strobe, either select, or that lane's own enable goes inactive; the other lane may stay in its write.
- R7: mode, drive_en, wr_stb and rdata follow a pin change after two rising clock edges (one sampling register, one output register); after reset mode is 2'b00 and drive_en, wr_stb and rdata are zero.
- R8: Lane 0 is lane_n[0], wdata[7:0] and rdata[7:0]; lane 1 is lane_n[1], wdata[15:8] and rdata[15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low port select |
| sel_hi | input | 1 | Active-high port select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| lane_n | input | 2 | Active-low byte lane enables |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| drive_en | output | 2 | Per-lane output drive enable |
| wr_stb | output | 2 | Per-lane write-in-progress indication |
| mode | output | 2 | 00 standby, 01 active idle, 10 read, 11 write |

## Verification
The assertions take for granted that the pins are steady at each rising clock edge and that reset is held for at least two edges, so every two-edge history they inspect starts from sampled pin values. The stimulus changes pins only on falling edges and holds each combination for at least two rising edges, so the sampled value is never ambiguous. Between operations the bench closes each write with one of the three deselect conditions and idles long enough for the commit to land before any read of the same word.

// File: rtl/dlsp_pkg.sv
package dlsp_pkg;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_READ  = 2'b10,
    MODE_WRITE = 2'b11
  } port_mode_e;

endpackage

// File: rtl/dlsp_pin_sampler.sv
module dlsp_pin_sampler #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              s_sel_n,
  output logic              s_sel_hi,
  output logic              s_we_n,
  output logic              s_oe_n,
  output logic [LANES-1:0]  s_lane_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata
);

  // One register stage on every pin; reset parks the port deselected.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_sel_n  <= 1'b1;
      s_sel_hi <= 1'b0;
      s_we_n   <= 1'b1;
      s_oe_n   <= 1'b1;
      s_lane_n <= '1;
      s_addr   <= '0;
      s_wdata  <= '0;
    end else begin
      s_sel_n  <= sel_n;
      s_sel_hi <= sel_hi;
      s_we_n   <= we_n;
      s_oe_n   <= oe_n;
      s_lane_n <= lane_n;
      s_addr   <= addr;
      s_wdata  <= wdata;
    end
  end

endmodule

// File: rtl/dlsp_ctrl_decode.sv
module dlsp_ctrl_decode
  import dlsp_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  output port_mode_e       mode,
  output logic [LANES-1:0] rd_lane,
  output logic [LANES-1:0] wr_lane
);

  logic chip_on;
  logic any_lane;

  assign chip_on  = !sel_n && sel_hi;
  assign any_lane = !(&lane_n);

  always_comb begin
    mode    = MODE_STBY;
    rd_lane = '0;
    wr_lane = '0;
    if (chip_on && any_lane) begin
      if (!we_n) begin
        // write wins over output enable
        mode    = MODE_WRITE;
        wr_lane = ~lane_n;
      end else if (!oe_n) begin
        mode    = MODE_READ;
        rd_lane = ~lane_n;
      end else begin
        mode    = MODE_IDLE;
      end
    end
  end

endmodule

// File: rtl/dlsp_lane_store.sv
module dlsp_lane_store #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_act,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wbyte,
  output logic              strobe_q,
  output logic [LANE_W-1:0] rbyte_q
);

  logic [LANE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] hold_addr;
  logic [LANE_W-1:0] hold_byte;
  logic              commit;

  // overlap was open last cycle and is closed now
  assign commit = strobe_q && !wr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      hold_addr <= '0;
      hold_byte <= '0;
    end else begin
      strobe_q <= wr_act;
      if (wr_act) begin
        hold_addr <= addr;
        hold_byte <= wbyte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit && !rst) begin
      mem[hold_addr] <= hold_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbyte_q <= '0;
    end else if (rd_act) begin
      rbyte_q <= mem[addr];
    end else begin
      rbyte_q <= '0;
    end
  end

endmodule

// File: rtl/dual_lane_sram_port.sv
module dual_lane_sram_port
  import dlsp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  drive_en,
  output logic [LANES-1:0]  wr_stb,
  output logic [1:0]        mode
);

  logic              s_sel_n, s_sel_hi, s_we_n, s_oe_n;
  logic [LANES-1:0]  s_lane_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  port_mode_e        mode_d;
  logic [LANES-1:0]  rd_lane, wr_lane;

  dlsp_pin_sampler #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) smp_i (
    .clk(clk), .rst(rst),
    .sel_n(sel_n), .sel_hi(sel_hi), .we_n(we_n), .oe_n(oe_n),
    .lane_n(lane_n), .addr(addr), .wdata(wdata),
    .s_sel_n(s_sel_n), .s_sel_hi(s_sel_hi), .s_we_n(s_we_n), .s_oe_n(s_oe_n),
    .s_lane_n(s_lane_n), .s_addr(s_addr), .s_wdata(s_wdata)
  );

  dlsp_ctrl_decode #(.LANES(LANES)) dec_i (
    .sel_n(s_sel_n), .sel_hi(s_sel_hi), .we_n(s_we_n), .oe_n(s_oe_n),
    .lane_n(s_lane_n), .mode(mode_d), .rd_lane(rd_lane), .wr_lane(wr_lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dlsp_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) st_i (
      .clk(clk), .rst(rst),
      .wr_act(wr_lane[g]), .rd_act(rd_lane[g]),
      .addr(s_addr), .wbyte(s_wdata[g*LANE_W +: LANE_W]),
      .strobe_q(wr_stb[g]), .rbyte_q(rdata[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_STBY;
      drive_en <= '0;
    end else begin
      mode     <= mode_d;
      drive_en <= rd_lane;
    end
  end

endmodule

// File: rtl/dlsp_checker.sv
module dlsp_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic             sel_hi,
  input logic             we_n,
  input logic [LANES-1:0] lane_n,
  input logic [LANES-1:0] drive_en,
  input logic [LANES-1:0] wr_stb,
  input logic [1:0]       mode
);

  // R1: a deselect seen two edges ago leaves the port quiet in standby
  a_r1_desel_standby: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 2) && !$past(rst) &&
     ($past(sel_n, 2) || !$past(sel_hi, 2) || (&$past(lane_n, 2))))
    |-> (mode == 2'b00 && drive_en == '0 && wr_stb == '0));

  // R4: a decoded write strobes exactly the enabled lanes
  a_r4_write_lanes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 2) && !$past(rst) &&
     !$past(sel_n, 2) && $past(sel_hi, 2) && !$past(we_n, 2) && !(&$past(lane_n, 2)))
    |-> (mode == 2'b11 && wr_stb == ~$past(lane_n, 2)));

  // R3: active-idle never drives or strobes
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (drive_en == '0 && wr_stb == '0));

  // R4: no lane is driven while any lane is written
  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (wr_stb != '0) |-> (drive_en == '0 && mode == 2'b11));

  // R2: drive only happens in read mode
  a_r2_drive_is_read: assert property (@(posedge clk) disable iff (rst)
    (drive_en != '0) |-> (mode == 2'b10));

endmodule

bind dual_lane_sram_port dlsp_checker #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .sel_n(sel_n), .sel_hi(sel_hi), .we_n(we_n),
  .lane_n(lane_n), .drive_en(drive_en), .wr_stb(wr_stb), .mode(mode)
);

// File: tb/dual_lane_sram_port_tb_top.sv
module dual_lane_sram_port_tb_top;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, sel_hi = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]    lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    drive_en, wr_stb, mode;

  logic [15:0]   ref_mem [DEPTH];
  logic [DEPTH-1:0] known;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_lane_sram_port #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel_hi(sel_hi), .we_n(we_n),
    .oe_n(oe_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drive_en(drive_en), .wr_stb(wr_stb), .mode(mode)
  );

  function automatic logic [1:0] exp_mode(logic sn, logic sh, logic wn, logic on, logic [1:0] ln);
    if (sn || !sh || ln == 2'b11) return 2'b00;
    if (!wn) return 2'b11;
    if (!on) return 2'b10;
    return 2'b01;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic sn, logic sh, logic wn, logic on, logic [1:0] ln,
                       logic [AW-1:0] a, logic [15:0] d);
    sel_n = sn; sel_hi = sh; we_n = wn; oe_n = on; lane_n = ln; addr = a; wdata = d;
  endtask

  // R6: close with one of three deselect causes
  task automatic close_op(int how);
    case (how)
      0: sel_n = 1'b1;
      1: sel_hi = 1'b0;
      default: lane_n = 2'b11;
    endcase
    edges(2);
  endtask

  function automatic logic [15:0] exp_read(logic [AW-1:0] a, logic [1:0] ln);
    logic [15:0] r = '0;
    if (!ln[0]) r[7:0]  = ref_mem[a][7:0];
    if (!ln[1]) r[15:8] = ref_mem[a][15:8];
    return r;
  endfunction

  // one operation: drive, check decode after two edges, close, update model
  task automatic op(logic sn, logic sh, logic wn, logic on, logic [1:0] ln,
                    logic [AW-1:0] a, logic [15:0] d, int how);
    logic [1:0] em;
    logic [1:0] ed, ew;
    em = exp_mode(sn, sh, wn, on, ln);
    ed = (em == 2'b10) ? ~ln : 2'b00;
    ew = (em == 2'b11) ? ~ln : 2'b00;
    drive(sn, sh, wn, on, ln, a, d);
    edges(2);
    chk(mode == em, "R1/R3 mode", 32'(mode), 32'(em));
    chk(drive_en == ed, "R2 drive_en", 32'(drive_en), 32'(ed));
    chk(wr_stb == ew, "R4 wr_stb", 32'(wr_stb), 32'(ew));
    if (em == 2'b10 && (known[a] || ln == 2'b11))
      chk(rdata == exp_read(a, ln), "R8 rdata lanes", 32'(rdata), 32'(exp_read(a, ln)));
    else if (em != 2'b10)
      chk(rdata == 16'h0, "R2 rdata undriven", 32'(rdata), 32'h0);
    close_op(how);
    if (em == 2'b11) begin
      if (!ln[0]) ref_mem[a][7:0]  = d[7:0];
      if (!ln[1]) ref_mem[a][15:8] = d[15:8];
      if (ln == 2'b00) known[a] = 1'b1;
    end
  endtask

  task automatic read_chk(logic [AW-1:0] a, logic [15:0] e, string tag);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, a, 16'h0);
    edges(2);
    chk(rdata == e, tag, 32'(rdata), 32'(e));
    close_op(0);
  endtask

  initial begin
    int seed;
    logic [15:0] d1, d2;
    seed = 32'h5eed;
    void'($urandom(seed));
    known = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mode == 2'b00 && drive_en == 0 && wr_stb == 0 && rdata == 0,
        "R7 reset state", {mode, drive_en, wr_stb, rdata}, 32'h0);
    rst = 1'b0;

    // fill every word with both lanes so reads have known contents
    for (int a = 0; a < DEPTH; a++)
      op(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, AW'(a), 16'($urandom), a % 3);

    // truth table walk: every control combination
    for (int c = 0; c < 64; c++) begin
      logic [5:0] v = 6'(c);
      op(v[5], v[4], v[3], v[2], v[1:0], AW'($urandom), 16'($urandom), c % 3);
    end

    // R5: data changing during the overlap, last sample wins; lane 1 untouched
    d1 = ref_mem[5];
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, AW'(5), 16'h1111);
    @(negedge clk); wdata = 16'h2222;
    @(negedge clk); wdata = 16'h33C7;
    edges(1);
    close_op(1);
    read_chk(AW'(5), {d1[15:8], 8'hC7}, "R5 last sample, other lane kept");

    // R6: lane 1 ends early, lane 0 continues with new data
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, AW'(9), 16'hAB12);
    edges(2);
    lane_n = 2'b10; wdata = 16'h77EE;
    edges(2);
    chk(wr_stb == 2'b01, "R6 lane1 closed alone", 32'(wr_stb), 32'h1);
    close_op(0);
    read_chk(AW'(9), 16'hABEE, "R6 per-lane commit");

    // R6/R7: write closed by we_n rising while output enable is low
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, AW'(12), 16'h5A3C);
    edges(2);
    we_n = 1'b1;
    edges(1);
    chk(mode == 2'b11, "R7 one edge still write", 32'(mode), 32'h3);
    edges(2);
    chk(mode == 2'b10 && rdata == 16'h5A3C, "R6 we_n close then read",
        {mode, rdata}, {2'b10, 16'h5A3C});
    close_op(2);
    ref_mem[12] = 16'h5A3C;

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic sn, sh, wn, on;
      sn = ($urandom % 5) == 0;
      sh = ($urandom % 5) != 0;
      wn = $urandom % 2;
      on = $urandom % 2;
      op(sn, sh, wn, on, 2'($urandom), AW'($urandom), 16'($urandom), int'($urandom % 3));
    end

    // final sweep: read back every word
    for (int a = 0; a < DEPTH; a++)
      read_chk(AW'(a), ref_mem[a], "R5 final contents");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R7 act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule